// File: doc/BRIEF.md
# Ping-Pong Receive Buffer for a USB OUT Endpoint

This block holds received data for one bulk or interrupt OUT endpoint. It has two banks of `DEPTH` bytes that take packets in strict turn. The packet engine marks the start of a packet and delivers its bytes one per cycle. It then marks the end of the packet with a good or bad status. From this the block decides the handshake: ACK when the packet was stored, NAK when it was refused. A packet with a bad status gets no handshake and leaves its bank free.

Firmware reads one bank at a time, always the one that filled first. It reads through a byte port that advances on each read strobe, and it can see that bank's byte count and both received flags. When firmware has read a bank, a release strobe clears that bank's flag and moves the read side to the other bank. An interrupt request stays high while any bank holds data. A synchronous endpoint clear returns the block to its reset state, and it also abandons any packet in progress.

Top module: `pingpong_out_buf`

## Requirements
- R1: After reset or endpoint clear, the first packet that is stored goes to bank 0. Each later stored packet goes to the bank other than the previous one, whatever packets were refused or bad in between.
- R2: A packet that ends with `pkt_ok`=1 and was accepted sets the received flag of its bank (`rx_flags` bit 0 for bank 0, bit 1 for bank 1). It also gives `hs_valid`=1 with `hs_nak`=0 in the cycle after `pkt_end`.
- R3: A packet is refused if its target bank still holds data at `pkt_start`, which happens only when both banks are held. A refused packet that ends good gives `hs_valid`=1 with `hs_nak`=1. It changes no flag, count or stored byte.
- R4: Only the first `DEPTH` bytes of a packet are stored. Any further bytes are dropped without effect.
- R5: `rd_count` shows the number of bytes stored for the packet held in the current read bank, which is never more than `DEPTH`.
- R6: A packet that ends with `pkt_ok`=0 gives no handshake and sets no flag. The next good packet goes to the same bank.
- R7: `rd_data` shows the byte of the read bank at the read index. Each `fw_rd` strobe moves the index up by one, and the index starts at 0.
- R8: A `fw_release` strobe while the read bank's flag is set clears that flag. It also moves the read side to the other bank and sets the index to 0. While the read bank's flag is clear, the strobe has no effect.
- R9: `irq` is high exactly while at least one received flag is set.
- R10: A cycle with `ep_clr`=1 clears both flags, both counts and the handshake. It points both the write side and the read side at bank 0 and drops any packet in progress, including its later `pkt_end`.
- R11: After reset, all flags, `irq`, `hs_valid`, `rd_bank` and `rd_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_clr | input | 1 | Synchronous endpoint clear |
| pkt_start | input | 1 | Start of an OUT data packet |
| pkt_wr | input | 1 | Packet byte valid |
| pkt_data | input | DW | Packet byte |
| pkt_end | input | 1 | End of packet |
| pkt_ok | input | 1 | Packet status at `pkt_end` (1 = good) |
| hs_valid | output | 1 | Handshake decision valid (one cycle) |
| hs_nak | output | 1 | 1 = NAK, 0 = ACK |
| fw_rd | input | 1 | Firmware read strobe, advances the read index |
| fw_release | input | 1 | Firmware release of the read bank |
| rd_data | output | DW | Byte at the read index of the read bank |
| rd_count | output | CW | Byte count of the read bank |
| rd_bank | output | 1 | Bank the firmware side is reading |
| rx_flags | output | 2 | Received flags, bit n for bank n |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a release that lands in the same cycle as the end of a stored packet. This case decides whether a flag can be set and cleared at once, and whether the alternation order still holds. The bench runs a packet and a short drain in parallel threads, so their strobes overlap at varying offsets. A mixed loop of zero-length, oversized and bad packets reaches the refused case while both banks are held. An endpoint clear in the middle of a packet checks that its late end marker is ignored.

// File: rtl/pingpong_out_buf.sv
module pingpong_out_buf #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ep_clr,
  input  logic          pkt_start,
  input  logic          pkt_wr,
  input  logic [DW-1:0] pkt_data,
  input  logic          pkt_end,
  input  logic          pkt_ok,
  output logic          hs_valid,
  output logic          hs_nak,
  input  logic          fw_rd,
  input  logic          fw_release,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] rd_count,
  output logic          rd_bank,
  output logic [1:0]    rx_flags,
  output logic          irq
);

  logic [DW-1:0] mem [2][DEPTH];
  logic [CW-1:0] cnt [2];
  logic [1:0]    full;
  logic          wr_bank, in_pkt, acc;
  logic [CW-1:0] wcnt;
  logic [AW-1:0] rd_idx;

  wire store   = in_pkt && acc && pkt_wr && !pkt_start && !pkt_end && (wcnt < CW'(DEPTH));
  wire done_ok = in_pkt && pkt_end && !pkt_start && pkt_ok;
  wire fill    = done_ok && acc;
  wire rel     = fw_release && full[rd_bank];
  wire [1:0] set_m = fill ? (2'b01 << wr_bank) : 2'b00;
  wire [1:0] clr_m = rel  ? (2'b01 << rd_bank) : 2'b00;

  always_ff @(posedge clk)
    if (store) mem[wr_bank][wcnt[AW-1:0]] <= pkt_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= '0; wr_bank <= 1'b0; rd_bank <= 1'b0; in_pkt <= 1'b0; acc <= 1'b0;
      wcnt <= '0; rd_idx <= '0; cnt[0] <= '0; cnt[1] <= '0;
      hs_valid <= 1'b0; hs_nak <= 1'b0;
    end else if (ep_clr) begin
      full <= '0; wr_bank <= 1'b0; rd_bank <= 1'b0; in_pkt <= 1'b0; acc <= 1'b0;
      wcnt <= '0; rd_idx <= '0; cnt[0] <= '0; cnt[1] <= '0;
      hs_valid <= 1'b0; hs_nak <= 1'b0;
    end else begin
      hs_valid <= done_ok;
      hs_nak   <= done_ok && !acc;
      full     <= (full & ~clr_m) | set_m;
      if (pkt_start) begin
        in_pkt <= 1'b1;
        acc    <= !full[wr_bank];
        wcnt   <= '0;
      end else if (pkt_end) begin
        in_pkt <= 1'b0;
      end else if (store) begin
        wcnt <= wcnt + 1'b1;
      end
      if (fill) begin
        cnt[wr_bank] <= wcnt;
        wr_bank      <= !wr_bank;
      end
      if (rel) begin
        rd_bank <= !rd_bank;
        rd_idx  <= '0;
      end else if (fw_rd) begin
        rd_idx <= rd_idx + 1'b1;
      end
    end
  end

  assign rd_data  = mem[rd_bank][rd_idx];
  assign rd_count = cnt[rd_bank];
  assign rx_flags = full;
  assign irq      = |full;

  // R1
  alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && !ep_clr) |=> (wr_bank != $past(wr_bank)));
  // R2
  ack_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && !hs_nak) |-> ($countones(rx_flags) >= 1));
  // R4
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[0] <= CW'(DEPTH)) && (cnt[1] <= CW'(DEPTH)) && (wcnt <= CW'(DEPTH)));
  // R6
  bad_no_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt && pkt_end && !pkt_start && !pkt_ok && !ep_clr) |=> !hs_valid);
  // R8
  release_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_release && rx_flags[rd_bank] && !ep_clr) |=> (rd_bank != $past(rd_bank)) && (rd_idx == '0));
  // R3
  nak_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_nak) |-> $stable(cnt[0]) || $stable(cnt[1]));

endmodule

// File: tb/pingpong_out_buf_test.sv
module pingpong_out_buf_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 0, rst_n = 0, ep_clr = 0;
  logic pkt_start = 0, pkt_wr = 0, pkt_end = 0, pkt_ok = 0;
  logic [7:0] pkt_data = 0;
  logic fw_rd = 0, fw_release = 0;
  logic hs_valid, hs_nak, rd_bank, irq;
  logic [7:0] rd_data;
  logic [6:0] rd_count;
  logic [1:0] rx_flags;

  pingpong_out_buf #(.DEPTH(DEPTH), .DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .ep_clr(ep_clr),
    .pkt_start(pkt_start), .pkt_wr(pkt_wr), .pkt_data(pkt_data),
    .pkt_end(pkt_end), .pkt_ok(pkt_ok),
    .hs_valid(hs_valid), .hs_nak(hs_nak),
    .fw_rd(fw_rd), .fw_release(fw_release),
    .rd_data(rd_data), .rd_count(rd_count), .rd_bank(rd_bank),
    .rx_flags(rx_flags), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // behavioural reference
  byte unsigned mm [2][DEPTH];
  int  mcnt [2];
  bit  mf [2];
  int  mwb, mrb, mri, tn;
  bit  minp, macc, m_hsv, m_hsn, rel;
  byte unsigned tbuf [DEPTH];

  always @(posedge clk) begin
    if (!rst_n || ep_clr) begin
      mf[0] = 0; mf[1] = 0; mcnt[0] = 0; mcnt[1] = 0;
      mwb = 0; mrb = 0; mri = 0; tn = 0; minp = 0; macc = 0; m_hsv = 0; m_hsn = 0;
    end else begin
      rel = fw_release && mf[mrb];
      m_hsv = 0; m_hsn = 0;
      if (pkt_start) begin
        minp = 1; macc = !mf[mwb]; tn = 0;
      end else if (pkt_end && minp) begin
        minp = 0;
        if (pkt_ok) begin
          m_hsv = 1; m_hsn = !macc;
          if (macc) begin
            mf[mwb] = 1;
            for (int k = 0; k < tn; k++) mm[mwb][k] = tbuf[k];
            mcnt[mwb] = tn;
            mwb ^= 1;
          end
        end
      end else if (pkt_wr && minp && macc && tn < DEPTH) begin
        tbuf[tn] = pkt_data; tn++;
      end
      if (rel) begin mf[mrb] = 0; mrb ^= 1; mri = 0; end
      else if (fw_rd) mri = (mri + 1) % DEPTH;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rx_flags == {mf[1], mf[0]}, "R2", "rx_flags", rx_flags, {mf[1], mf[0]});
      chk(irq == (mf[0] | mf[1]), "R9", "irq", irq, mf[0] | mf[1]);
      chk(rd_bank == mrb[0], "R8", "rd_bank", rd_bank, mrb);
      chk(rd_count == mcnt[mrb], "R5", "rd_count", rd_count, mcnt[mrb]);
      chk(hs_valid == m_hsv, "R3", "hs_valid", hs_valid, m_hsv);
      if (m_hsv) chk(hs_nak == m_hsn, "R3", "hs_nak", hs_nak, m_hsn);
      if (mf[mrb] && mri < mcnt[mrb])
        chk(rd_data == mm[mrb][mri], "R7", "rd_data", rd_data, mm[mrb][mri]);
    end
  end

  task automatic summary();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      summary();
    end
  end

  task automatic send(int n, bit ok, int seed);
    @(negedge clk); pkt_start = 1;
    @(negedge clk); pkt_start = 0;
    for (int i = 0; i < n; i++) begin
      pkt_wr = 1; pkt_data = 8'(seed * 13 + i * 7); @(negedge clk);
    end
    pkt_wr = 0; pkt_end = 1; pkt_ok = ok;
    @(negedge clk); pkt_end = 0; pkt_ok = 0;
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); fw_rd = 1; end
    @(negedge clk); fw_rd = 0; fw_release = 1;
    @(negedge clk); fw_release = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;                       // R11 reset state compared on the next negedges
    repeat (2) @(negedge clk);
    send(10, 1, 1);                  // R1 R2 bank 0
    send(64, 1, 2);                  // R1 bank 1, full size
    send(5, 1, 3);                   // R3 both held: NAK
    drain(10);                       // R7 R8 bank 0
    send(70, 1, 4);                  // R4 capped at 64 into bank 0
    drain(64);
    drain(64);
    @(negedge clk); fw_release = 1;  // R8 ignored with no flag set
    @(negedge clk); fw_release = 0;
    repeat (2) @(negedge clk);
    send(8, 0, 5);                   // R6 bad, bank 1 stays free
    send(8, 1, 6);                   // R6 same bank takes the next good packet
    fork
      send(20, 1, 7);
      begin repeat (3) @(negedge clk); drain(8); end
    join
    fork                             // R10 clear mid-packet
      send(30, 1, 8);
      begin repeat (10) @(negedge clk); ep_clr = 1; @(negedge clk); ep_clr = 0; end
    join
    repeat (2) @(negedge clk);
    for (int i = 0; i < 24; i++) begin
      send((i * 11) % 72, (i % 4) != 3, i + 20);
      if (i % 3 == 0) drain(i % 9);
      if (i % 5 == 2) fork send(4, 1, i); drain(2); join
    end
    repeat (4) @(negedge clk);
    summary();
  end
endmodule